// File: doc/BRIEF.md
# Complex Cross-Multiply Accumulator

This block builds every correlation product of a channelised multi-input complex stream. Each input beat carries one complex sample from every input, all for the same frequency channel. Channels arrive in ascending order, and one frame is one full pass over the channels. For each beat the block takes every ordered pair (i, j) with i ≤ j, self-pairs included, and forms x_i · conj(x_j). It adds each product into an accumulator that belongs to that pair and that channel. The block works through the pairs one per clock cycle and holds the input off while it does so.

After 2^LOG2_INT frames the integration ends and the block drains its accumulator bank as a stream of averaged visibilities. Each output beat is tagged with its pair and its channel. The block divides each sum by the frame count with an arithmetic right shift and clears each accumulator as it is read. The input is held off until the drain has finished. The pair indices come from a table that is built when the design elaborates, so no divider or modulo logic is needed.

Top module: `xcorr_accum`

## Requirements
- R1: In the cycle after a reset cycle, in_ready is 1 and out_valid is 0.
- R2: Each integration produces NP = N_IN(N_IN+1)/2 products per channel. Pair number p counts row-major over i ≤ j: (0,0), (0,1) … (0,N_IN-1), (1,1), (1,2) …. The drain emits NP·N_CH beats, and beat number d carries pair p = d / N_CH and channel d mod N_CH, so consecutive beats step through the channels of one pair.
- R3: The product of pair (i, j) is re = ar·br + ai·bi and im = ai·br − ar·bi, where a = x_i and b = x_j. Sample k sits in bits [k·W +: W] of in_re and in_im as signed two's complement.
- R4: Beats are assigned to channels 0, 1 … N_CH-1 in order of acceptance. The channel counter wraps at the end of each frame, and an integration sums 2^LOG2_INT frames.
- R5: A dumped value equals the accumulated sum shifted right arithmetically by LOG2_INT bits, which rounds toward minus infinity.
- R6: Each accumulator is cleared when its beat is taken. The next integration therefore sums only the beats accepted after the drain.
- R7: After each accepted beat, in_ready is 0 for exactly NP cycles. It stays 0 for the whole drain, and in_valid has no effect while in_ready is 0.
- R8: While out_valid is 1 and out_ready is 0, the beat and all of its fields hold unchanged.
- R9: out_last is 1 only on the final beat of a drain.
- R10: Full-scale inputs of −32768 on every component, held for a whole integration, accumulate without overflow and give the exact average.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block accepts an input beat |
| in_re | input | N_IN·W | Real parts, sample k in bits [k·W +: W] |
| in_im | input | N_IN·W | Imaginary parts, same layout |
| out_valid | output | 1 | Averaged visibility present |
| out_ready | input | 1 | Downstream takes the beat |
| out_i | output | clog2(N_IN) | First input of the pair |
| out_j | output | clog2(N_IN) | Second (conjugated) input of the pair |
| out_chan | output | clog2(N_CH) | Channel of the beat |
| out_re | output | 2W+2 | Averaged real part, signed |
| out_im | output | 2W+2 | Averaged imaginary part, signed |
| out_last | output | 1 | Final beat of a drain |

## Verification
An accepted input beat drops in_ready at the next rising edge, and in_ready comes back NP edges later. When the final beat of an integration is accepted, the first drain beat follows NP edges after the acceptance. A drain beat advances one edge after a cycle in which out_valid and out_ready are both high. The bench carries these counts in a behavioural model that advances on each rising edge and compares every output on the following falling edge. That way each result is read in the cycle it is due and never while it is changing.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAC  = 2'd1,
        ST_DUMP = 2'd2
    } cmac_state_e;

    // number of unique pairs, self-pairs included
    function automatic int pair_count(input int n);
        return n * (n + 1) / 2;
    endfunction

    // row (first input) of pair number p, row-major over i <= j
    function automatic int pair_row(input int n, input int p);
        int k;
        k = p;
        for (int i = 0; i < n; i++) begin
            if (k < n - i) return i;
            k = k - (n - i);
        end
        return 0;
    endfunction

    // column (second input) of pair number p
    function automatic int pair_col(input int n, input int p);
        int k;
        k = p;
        for (int i = 0; i < n; i++) begin
            if (k < n - i) return i + k;
            k = k - (n - i);
        end
        return 0;
    endfunction

endpackage

// File: rtl/cmac_pair_lut.sv
module cmac_pair_lut #(
    parameter int N_IN = 4,
    parameter int NP   = 10,
    parameter int PIW  = 4,
    parameter int IW   = 2
) (
    input  logic [PIW-1:0] pair_idx,
    output logic [IW-1:0]  idx_i,
    output logic [IW-1:0]  idx_j
);
    logic [IW-1:0] tab_i [NP];
    logic [IW-1:0] tab_j [NP];

    for (genvar g = 0; g < NP; g++) begin : g_entry
        localparam int ROW = cmac_pkg::pair_row(N_IN, g);
        localparam int COL = cmac_pkg::pair_col(N_IN, g);
        assign tab_i[g] = IW'(ROW);
        assign tab_j[g] = IW'(COL);
    end

    always_comb begin
        idx_i = '0;
        idx_j = '0;
        if (int'(pair_idx) < NP) begin
            idx_i = tab_i[pair_idx];
            idx_j = tab_j[pair_idx];
        end
    end
endmodule

// File: rtl/cmac_conj_mult.sv
module cmac_conj_mult #(
    parameter int W  = 16,
    parameter int PW = 34
) (
    input  logic signed [W-1:0]  a_re,
    input  logic signed [W-1:0]  a_im,
    input  logic signed [W-1:0]  b_re,
    input  logic signed [W-1:0]  b_im,
    output logic signed [PW-1:0] p_re,
    output logic signed [PW-1:0] p_im
);
    logic signed [PW-1:0] ar, ai, br, bi;

    always_comb begin
        ar = PW'(a_re);
        ai = PW'(a_im);
        br = PW'(b_re);
        bi = PW'(b_im);
        // a * conj(b)
        p_re = ar * br + ai * bi;
        p_im = ai * br - ar * bi;
    end
endmodule

// File: rtl/cmac_acc_bank.sv
module cmac_acc_bank #(
    parameter int DEPTH    = 80,
    parameter int AW       = 7,
    parameter int PW       = 34,
    parameter int LOG2_INT = 1,
    localparam int ACC_W   = PW + LOG2_INT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 add_en,
    input  logic [AW-1:0]        add_addr,
    input  logic signed [PW-1:0] add_re,
    input  logic signed [PW-1:0] add_im,
    input  logic [AW-1:0]        rd_addr,
    input  logic                 clr_en,
    output logic signed [PW-1:0] rd_re,
    output logic signed [PW-1:0] rd_im
);
    logic signed [ACC_W-1:0] mem_re [DEPTH];
    logic signed [ACC_W-1:0] mem_im [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < DEPTH; d++) begin
                mem_re[d] <= '0;
                mem_im[d] <= '0;
            end
        end else begin
            if (add_en) begin
                mem_re[add_addr] <= mem_re[add_addr] + ACC_W'(add_re);
                mem_im[add_addr] <= mem_im[add_addr] + ACC_W'(add_im);
            end
            if (clr_en) begin
                mem_re[rd_addr] <= '0;
                mem_im[rd_addr] <= '0;
            end
        end
    end

    assign rd_re = PW'(mem_re[rd_addr] >>> LOG2_INT);
    assign rd_im = PW'(mem_im[rd_addr] >>> LOG2_INT);

    // one guard bit beyond the accumulator shows any wrap of the sum
    logic signed [ACC_W:0] guard_re, guard_im;
    assign guard_re = $signed({mem_re[add_addr][ACC_W-1], mem_re[add_addr]}) + (ACC_W+1)'(add_re);
    assign guard_im = $signed({mem_im[add_addr][ACC_W-1], mem_im[add_addr]}) + (ACC_W+1)'(add_im);

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        add_en |-> (guard_re[ACC_W] == guard_re[ACC_W-1]) && (guard_im[ACC_W] == guard_im[ACC_W-1]));
endmodule

// File: rtl/xcorr_accum.sv
module xcorr_accum #(
    parameter int N_IN     = 4,
    parameter int N_CH     = 8,
    parameter int W        = 16,
    parameter int LOG2_INT = 1,
    localparam int IW      = $clog2(N_IN),
    localparam int CW      = $clog2(N_CH),
    localparam int PW      = 2 * W + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [N_IN*W-1:0]   in_re,
    input  logic [N_IN*W-1:0]   in_im,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [IW-1:0]       out_i,
    output logic [IW-1:0]       out_j,
    output logic [CW-1:0]       out_chan,
    output logic [PW-1:0]       out_re,
    output logic [PW-1:0]       out_im,
    output logic                out_last
);
    import cmac_pkg::*;

    localparam int NP    = pair_count(N_IN);
    localparam int PIW   = (NP > 1) ? $clog2(NP) : 1;
    localparam int DEPTH = NP * N_CH;
    localparam int AW    = $clog2(DEPTH);
    localparam int FW    = (LOG2_INT > 0) ? LOG2_INT : 1;

    cmac_state_e      state;
    logic [PIW-1:0]   pair_cnt;
    logic [CW-1:0]    cur_ch;
    logic [CW-1:0]    dump_ch;
    logic [FW-1:0]    frame_cnt;
    logic signed [W-1:0] vec_re [N_IN];
    logic signed [W-1:0] vec_im [N_IN];

    logic             pair_end, chan_end, frame_end, dump_take;
    logic [IW-1:0]    lut_i, lut_j;
    logic signed [PW-1:0] prod_re, prod_im;
    logic signed [PW-1:0] avg_re, avg_im;
    logic [AW-1:0]    mac_addr, dump_addr;

    assign pair_end  = (pair_cnt == PIW'(NP - 1));
    assign frame_end = (frame_cnt == FW'((1 << LOG2_INT) - 1));
    assign dump_take = (state == ST_DUMP) && out_ready;
    assign chan_end  = (state == ST_DUMP) ? (dump_ch == CW'(N_CH - 1))
                                          : (cur_ch == CW'(N_CH - 1));

    // pair decode shared by the multiply phase and the drain phase
    cmac_pair_lut #(.N_IN(N_IN), .NP(NP), .PIW(PIW), .IW(IW)) u_lut (
        .pair_idx (pair_cnt),
        .idx_i    (lut_i),
        .idx_j    (lut_j)
    );

    cmac_conj_mult #(.W(W), .PW(PW)) u_mult (
        .a_re (vec_re[lut_i]),
        .a_im (vec_im[lut_i]),
        .b_re (vec_re[lut_j]),
        .b_im (vec_im[lut_j]),
        .p_re (prod_re),
        .p_im (prod_im)
    );

    assign mac_addr  = AW'(int'(pair_cnt) * N_CH + int'(cur_ch));
    assign dump_addr = AW'(int'(pair_cnt) * N_CH + int'(dump_ch));

    cmac_acc_bank #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .LOG2_INT(LOG2_INT)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .add_en   (state == ST_MAC),
        .add_addr (mac_addr),
        .add_re   (prod_re),
        .add_im   (prod_im),
        .rd_addr  (dump_addr),
        .clr_en   (dump_take),
        .rd_re    (avg_re),
        .rd_im    (avg_im)
    );

    // sample capture
    always_ff @(posedge clk) begin
        if (state == ST_IDLE && in_valid) begin
            for (int k = 0; k < N_IN; k++) begin
                vec_re[k] <= in_re[k*W +: W];
                vec_im[k] <= in_im[k*W +: W];
            end
        end
    end

    // sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pair_cnt  <= '0;
            cur_ch    <= '0;
            dump_ch   <= '0;
            frame_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        pair_cnt <= '0;
                        state    <= ST_MAC;
                    end
                end
                ST_MAC: begin
                    if (pair_end) begin
                        pair_cnt <= '0;
                        if (chan_end) begin
                            cur_ch <= '0;
                            if (frame_end) begin
                                frame_cnt <= '0;
                                dump_ch   <= '0;
                                state     <= ST_DUMP;
                            end else begin
                                frame_cnt <= frame_cnt + 1'b1;
                                state     <= ST_IDLE;
                            end
                        end else begin
                            cur_ch <= cur_ch + 1'b1;
                            state  <= ST_IDLE;
                        end
                    end else begin
                        pair_cnt <= pair_cnt + 1'b1;
                    end
                end
                ST_DUMP: begin
                    if (out_ready) begin
                        if (chan_end) begin
                            dump_ch <= '0;
                            if (pair_end) begin
                                pair_cnt <= '0;
                                state    <= ST_IDLE;
                            end else begin
                                pair_cnt <= pair_cnt + 1'b1;
                            end
                        end else begin
                            dump_ch <= dump_ch + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign in_ready  = (state == ST_IDLE);
    assign out_valid = (state == ST_DUMP);
    assign out_i     = lut_i;
    assign out_j     = lut_j;
    assign out_chan  = dump_ch;
    assign out_re    = avg_re;
    assign out_im    = avg_im;
    assign out_last  = (state == ST_DUMP) && pair_end && chan_end;

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R7
    drain_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R8
    beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)
            && $stable(out_i) && $stable(out_j) && $stable(out_chan) && $stable(out_last)));

    // R9
    last_in_drain_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R2
    upper_triangle_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_i <= out_j));
endmodule

// File: tb/xcorr_accum_bench.sv
module xcorr_accum_bench;
    localparam int N_IN     = 4;
    localparam int N_CH     = 8;
    localparam int W        = 16;
    localparam int LOG2_INT = 1;
    localparam int NP       = N_IN * (N_IN + 1) / 2;
    localparam int NF       = 1 << LOG2_INT;
    localparam int DEPTH    = NP * N_CH;
    localparam int IW       = $clog2(N_IN);
    localparam int CW       = $clog2(N_CH);
    localparam int PW       = 2 * W + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [N_IN*W-1:0] in_re = '0;
    logic [N_IN*W-1:0] in_im = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [IW-1:0]     out_i, out_j;
    logic [CW-1:0]     out_chan;
    logic [PW-1:0]     out_re, out_im;
    logic              out_last;

    xcorr_accum #(.N_IN(N_IN), .N_CH(N_CH), .W(W), .LOG2_INT(LOG2_INT)) u_xcorr_accum (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_i(out_i), .out_j(out_j), .out_chan(out_chan),
        .out_re(out_re), .out_im(out_im), .out_last(out_last)
    );

    int errors = 0;
    int checks = 0;
    string phase = "R4";
    int rdy_mode = 0;

    int pi_tab [NP];
    int pj_tab [NP];
    longint m_acc_re [DEPTH];
    longint m_acc_im [DEPTH];
    int m_mode = 0;   // 0 waiting for input, 1 busy, 2 draining
    int m_cnt = 0;
    int m_ch = 0;
    int m_frame = 0;
    int m_didx = 0;
    int m_dumps = 0;

    task automatic check(input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL [%s] %s: actual=%0d expected=%0d", phase, what, act, exp);
        end
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_cnt = 0; m_ch = 0; m_frame = 0; m_didx = 0;
            for (int d = 0; d < DEPTH; d++) begin
                m_acc_re[d] = 0;
                m_acc_im[d] = 0;
            end
        end else begin
            case (m_mode)
                0: if (in_valid) begin
                    for (int p = 0; p < NP; p++) begin
                        longint ar, ai, br, bi;
                        ar = longint'($signed(in_re[pi_tab[p]*W +: W]));
                        ai = longint'($signed(in_im[pi_tab[p]*W +: W]));
                        br = longint'($signed(in_re[pj_tab[p]*W +: W]));
                        bi = longint'($signed(in_im[pj_tab[p]*W +: W]));
                        m_acc_re[p*N_CH + m_ch] += ar * br + ai * bi;
                        m_acc_im[p*N_CH + m_ch] += ai * br - ar * bi;
                    end
                    m_mode = 1;
                    m_cnt = NP;
                end
                1: begin
                    m_cnt--;
                    if (m_cnt == 0) begin
                        if (m_ch == N_CH - 1) begin
                            m_ch = 0;
                            if (m_frame == NF - 1) begin
                                m_frame = 0;
                                m_didx = 0;
                                m_mode = 2;
                            end else begin
                                m_frame++;
                                m_mode = 0;
                            end
                        end else begin
                            m_ch++;
                            m_mode = 0;
                        end
                    end
                end
                default: if (out_ready) begin
                    m_acc_re[m_didx] = 0;
                    m_acc_im[m_didx] = 0;
                    m_didx++;
                    if (m_didx == DEPTH) begin
                        m_didx = 0;
                        m_mode = 0;
                        m_dumps++;
                    end
                end
            endcase
        end
    end

    // comparison on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            int p, c;
            check("R7 in_ready", longint'(in_ready), longint'(m_mode == 0));
            check("R7 out_valid", longint'(out_valid), longint'(m_mode == 2));
            if (m_mode == 2) begin
                p = m_didx / N_CH;
                c = m_didx % N_CH;
                check("R2 out_i", longint'(out_i), longint'(pi_tab[p]));
                check("R2 out_j", longint'(out_j), longint'(pj_tab[p]));
                check("R2 out_chan", longint'(out_chan), longint'(c));
                check("R3 R5 out_re", longint'($signed(out_re)), m_acc_re[m_didx] >>> LOG2_INT);
                check("R3 R5 out_im", longint'($signed(out_im)), m_acc_im[m_didx] >>> LOG2_INT);
                check("R9 out_last", longint'(out_last), longint'(m_didx == DEPTH - 1));
            end else begin
                check("R9 out_last idle", longint'(out_last), 0);
            end
        end
    end

    always @(negedge clk) begin
        out_ready = (rdy_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
    end

    task automatic fill(input int kind, input int ch);
        for (int k = 0; k < N_IN; k++) begin
            case (kind)
                0: begin
                    in_re[k*W +: W] = W'($urandom);
                    in_im[k*W +: W] = W'($urandom);
                end
                1: begin
                    in_re[k*W +: W] = 16'h8000;
                    in_im[k*W +: W] = 16'h8000;
                end
                default: begin
                    in_re[k*W +: W] = W'(k + ch - 3);
                    in_im[k*W +: W] = W'(2 - k);
                end
            endcase
        end
    endtask

    task automatic run_integration(input int kind, input bit gaps);
        for (int f = 0; f < NF; f++) begin
            for (int c = 0; c < N_CH; c++) begin
                bit r;
                fill(kind, c);
                in_valid = 1'b1;
                do begin
                    r = in_ready;
                    @(negedge clk);
                end while (!r);
                in_valid = 1'b0;
                if (gaps) repeat ($urandom % 3) @(negedge clk);
            end
        end
        // offered beats during the busy and drain phases must be ignored (R7)
        begin
            int d0;
            d0 = m_dumps;
            fill(0, 0);
            in_valid = 1'b1;
            while (m_dumps == d0) @(negedge clk);
            in_valid = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int cnt;
        cnt = 0;
        for (int i = 0; i < N_IN; i++) begin
            for (int j = i; j < N_IN; j++) begin
                pi_tab[cnt] = i;
                pj_tab[cnt] = j;
                cnt++;
            end
        end
        repeat (3) @(negedge clk);
        phase = "R1";
        check("R1 in_ready after reset", longint'(in_ready), 1);
        check("R1 out_valid after reset", longint'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);

        phase = "R4";   // random data, idle gaps, free output
        run_integration(0, 1'b1);

        phase = "R8";   // random data, stalled output
        rdy_mode = 1;
        run_integration(0, 1'b0);
        rdy_mode = 0;

        phase = "R10";  // full-scale negative on every component
        run_integration(1, 1'b0);

        phase = "R6";   // small values; sums must start from zero again
        run_integration(2, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL [watchdog] run did not complete: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule